// File: doc/BRIEF.md
# Mode-Selectable Multiply-Accumulate Unit

This unit takes two unsigned 8-bit operands and a 16-bit addend. A 3-bit mode code picks one of eight arithmetic operations: product, product plus addend, addend plus operand word, and running accumulation. Each operation comes either as a combinational result or as a registered result.

The same code also decides where the output comes from. It can be the combinational datapath, a capture register, or a 24-bit feedback accumulator. The mode may change on any cycle with no setup step. Accumulation always continues from whatever the accumulator currently holds.

A clock enable gates every register update. A synchronous clear zeroes both registers. An asynchronous active-low reset does the same.

Top module: `mac_mode_unit`

## Requirements
- R1: Mode 3'b000 drives `result_o` with `op_a_i * op_b_i`, zero-extended, in the same cycle as the inputs.
- R2: Mode 3'b001 drives `result_o` with `op_a_i * op_b_i + addend_i` in the same cycle.
- R3: Mode 3'b011 drives `result_o` with `addend_i + {op_a_i, op_b_i}` in the same cycle, where `op_a_i` forms bits 15:8 of the operand word. No multiply is involved.
- R4: Mode 3'b010 adds `addend_i` into the accumulator at each enabled clock edge. `result_o` shows the accumulator.
- R5: Mode 3'b110 adds `op_a_i * op_b_i` into the accumulator at each enabled clock edge. `result_o` shows the accumulator.
- R6: Mode 3'b100 captures `op_a_i * op_b_i` at an enabled clock edge and shows it from the next cycle. `addend_i` has no effect in this mode.
- R7: Mode 3'b101 captures `op_a_i * op_b_i + addend_i` at an enabled clock edge and shows it from the next cycle.
- R8: Mode 3'b111 captures `addend_i + {op_a_i, op_b_i}` at an enabled clock edge and shows it from the next cycle.
- R9: The accumulator is 24 bits wide and wraps modulo 2^24.
- R10: While `en_i` is low, neither register changes. A registered or accumulating output therefore holds.
- R11: `clr_i` high at a clock edge zeroes the accumulator and the capture register, whatever the value of `en_i`.
- R12: `rst_ni` low zeroes both registers at once. After any mode change, accumulation resumes from the accumulator's current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Clock enable for both registers |
| clr_i | input | 1 | Synchronous clear of both registers |
| mode_i | input | 3 | Operation select |
| op_a_i | input | 8 | Multiplier operand A, also the upper byte of the operand word |
| op_b_i | input | 8 | Multiplier operand B, also the lower byte of the operand word |
| addend_i | input | 16 | Addend |
| result_o | output | 24 | Result |

## Verification
The bench first targets accumulator overflow. It feeds the largest addend, and then the largest product, for enough cycles to wrap past 2^24. A design that saturated, or kept fewer bits, would diverge at the wrap.

It also switches modes at random while the accumulator holds a value. A design that reset the accumulator on mode entry would lose the running total. So would one that let the capture register and the accumulator share state.

Further runs hold the clock enable low and assert the clear with the enable low. Together these show whether a register updates without enable, or whether the clear wrongly waits for it.

Finally, a product capture with a large addend present shows whether the addend leaks into mode 3'b100.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [2:0] {
    M_MUL      = 3'b000,
    M_MULADD   = 3'b001,
    M_ACC      = 3'b010,
    M_ADD      = 3'b011,
    M_MUL_R    = 3'b100,
    M_MULADD_R = 3'b101,
    M_MAC      = 3'b110,
    M_ADD_R    = 3'b111
  } mac_mode_e;

  typedef enum logic [1:0] {
    SRC_COMB = 2'd0,
    SRC_CAP  = 2'd1,
    SRC_ACC  = 2'd2
  } out_src_e;
endpackage

// File: rtl/mac_arith.sv
module mac_arith #(
  parameter int OP_W  = 8,
  parameter int ADD_W = 16,
  parameter int RES_W = 24
) (
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic [ADD_W-1:0] addend,
  input  logic             zero_addend,
  output logic [RES_W-1:0] prod,
  output logic [RES_W-1:0] prod_plus,
  output logic [RES_W-1:0] word_plus
);
  localparam int PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] raw_prod;
  logic [RES_W-1:0]  addend_ext;

  always_comb begin
    raw_prod   = PROD_W'(op_a) * PROD_W'(op_b);
    addend_ext = zero_addend ? '0 : RES_W'(addend);
    prod       = RES_W'(raw_prod);
    prod_plus  = RES_W'(raw_prod) + addend_ext;
    word_plus  = RES_W'({op_a, op_b}) + RES_W'(addend);
  end
endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             active,
  input  logic [RES_W-1:0] incr,
  output logic [RES_W-1:0] acc_q
);
  logic [RES_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clr)               acc_d = '0;
    else if (en && active) acc_d = acc_q + incr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/mac_capture.sv
module mac_capture #(
  parameter int RES_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             active,
  input  logic [RES_W-1:0] d,
  output logic [RES_W-1:0] q
);
  logic [RES_W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)               q_d = '0;
    else if (en && active) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/mac_mode_unit.sv
module mac_mode_unit
  import mac_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int ADD_W = 16,
  parameter int RES_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [2:0]       mode_i,
  input  logic [OP_W-1:0]  op_a_i,
  input  logic [OP_W-1:0]  op_b_i,
  input  logic [ADD_W-1:0] addend_i,
  output logic [RES_W-1:0] result_o
);
  localparam int MIN_RES_W = 2 * OP_W + 1;

  if (RES_W < MIN_RES_W || ADD_W > RES_W) begin : g_bad_width
    $error("mac_mode_unit: result width too small for operands");
  end

  mac_mode_e        mode;
  out_src_e         src;
  logic             zero_addend;
  logic             acc_active;
  logic             cap_active;
  logic [RES_W-1:0] prod, prod_plus, word_plus;
  logic [RES_W-1:0] acc_incr, cap_d, comb_val;
  logic [RES_W-1:0] acc_q, cap_q;

  always_comb begin
    mode        = mac_mode_e'(mode_i);
    zero_addend = (mode == M_MUL_R);
    acc_active  = (mode == M_ACC) || (mode == M_MAC);
    cap_active  = (mode == M_MUL_R) || (mode == M_MULADD_R) || (mode == M_ADD_R);
    acc_incr    = (mode == M_MAC) ? prod : RES_W'(addend_i);
    cap_d       = (mode == M_ADD_R) ? word_plus : prod_plus;
    unique case (mode)
      M_MUL:    comb_val = prod;
      M_MULADD: comb_val = prod_plus;
      default:  comb_val = word_plus;
    endcase
    if (acc_active)      src = SRC_ACC;
    else if (cap_active) src = SRC_CAP;
    else                 src = SRC_COMB;
  end

  mac_arith #(.OP_W(OP_W), .ADD_W(ADD_W), .RES_W(RES_W)) u_arith (
    .op_a        (op_a_i),
    .op_b        (op_b_i),
    .addend      (addend_i),
    .zero_addend (zero_addend),
    .prod        (prod),
    .prod_plus   (prod_plus),
    .word_plus   (word_plus)
  );

  mac_acc #(.RES_W(RES_W)) u_acc (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .clr    (clr_i),
    .en     (en_i),
    .active (acc_active),
    .incr   (acc_incr),
    .acc_q  (acc_q)
  );

  mac_capture #(.RES_W(RES_W)) u_cap (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .clr    (clr_i),
    .en     (en_i),
    .active (cap_active),
    .d      (cap_d),
    .q      (cap_q)
  );

  always_comb begin
    unique case (src)
      SRC_ACC: result_o = acc_q;
      SRC_CAP: result_o = cap_q;
      default: result_o = comb_val;
    endcase
  end
endmodule

// File: rtl/mac_mode_unit_chk.sv
module mac_mode_unit_chk
  import mac_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int ADD_W = 16,
  parameter int RES_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             clr_i,
  input logic [2:0]       mode_i,
  input logic [OP_W-1:0]  op_a_i,
  input logic [OP_W-1:0]  op_b_i,
  input logic [ADD_W-1:0] addend_i,
  input logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] prod_w;
  logic             reg_mode;

  assign prod_w   = RES_W'(op_a_i) * RES_W'(op_b_i);
  assign reg_mode = mode_i[2] || (mode_i == M_ACC);

  a_r1_mul_comb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == M_MUL) |-> (result_o == prod_w));

  a_r4_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && mode_i == M_ACC) |=>
      (mode_i != M_ACC || result_o == RES_W'($past(result_o) + RES_W'($past(addend_i)))));

  a_r6_mul_reg_no_addend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && mode_i == M_MUL_R) |=>
      (mode_i != M_MUL_R || result_o == RES_W'($past(op_a_i)) * RES_W'($past(op_b_i))));

  a_r7_muladd_reg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && mode_i == M_MULADD_R) |=>
      (mode_i != M_MULADD_R ||
       result_o == RES_W'($past(op_a_i)) * RES_W'($past(op_b_i)) + RES_W'($past(addend_i))));

  a_r10_hold_mac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i && mode_i == M_MAC) |=> (mode_i != M_MAC || $stable(result_o)));

  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!reg_mode || result_o == '0));
endmodule

bind mac_mode_unit mac_mode_unit_chk #(.OP_W(OP_W), .ADD_W(ADD_W), .RES_W(RES_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .clr_i    (clr_i),
  .mode_i   (mode_i),
  .op_a_i   (op_a_i),
  .op_b_i   (op_b_i),
  .addend_i (addend_i),
  .result_o (result_o)
);

// File: tb/mac_mode_unit_bench.sv
module mac_mode_unit_bench;
  localparam int RES_W = 24;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        en_i;
  logic        clr_i;
  logic [2:0]  mode_i;
  logic [7:0]  op_a_i, op_b_i;
  logic [15:0] addend_i;
  logic [23:0] result_o;

  typedef struct {
    logic [23:0] val;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;
  logic [23:0] m_acc, m_cap;

  always #5 clk_i = ~clk_i;

  mac_mode_unit u_mac_mode_unit (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .clr_i    (clr_i),
    .mode_i   (mode_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .addend_i (addend_i),
    .result_o (result_o)
  );

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'b000:  return "R1";
      3'b001:  return "R2";
      3'b011:  return "R3";
      3'b010:  return "R4";
      3'b110:  return "R5";
      3'b100:  return "R6";
      3'b101:  return "R7";
      default: return "R8";
    endcase
  endfunction

  // One cycle: drive inputs at the falling edge, push the value expected just
  // before the next rising edge, then advance the model across that edge.
  task automatic step(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b,
                      input logic [15:0] ad, input logic en, input logic clr,
                      input string tag);
    logic [23:0] prod, word, e;
    exp_t it;
    @(negedge clk_i);
    mode_i = m; op_a_i = a; op_b_i = b; addend_i = ad; en_i = en; clr_i = clr;
    prod = 24'(a) * 24'(b);
    word = 24'({a, b}) + 24'(ad);
    case (m)
      3'b000:          e = prod;
      3'b001:          e = prod + 24'(ad);
      3'b011:          e = word;
      3'b010, 3'b110:  e = m_acc;
      default:         e = m_cap;
    endcase
    it.val = e;
    it.tag = (tag == "") ? mode_tag(m) : tag;
    sb_q.push_back(it);
    if (clr) begin
      m_acc = '0; m_cap = '0;
    end else if (en) begin
      case (m)
        3'b010:  m_acc = m_acc + 24'(ad);
        3'b110:  m_acc = m_acc + prod;
        3'b100:  m_cap = prod;
        3'b101:  m_cap = prod + 24'(ad);
        3'b111:  m_cap = word;
        default: ;
      endcase
    end
  endtask

  // Monitor: compare shortly before each rising edge.
  initial begin
    forever begin
      @(negedge clk_i);
      #3;
      if (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        checks++;
        if (result_o !== it.val) begin
          fails++;
          $display("FAIL %s: result_o=%h expected=%h mode=%b", it.tag, result_o, it.val, mode_i);
        end
      end
    end
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; en_i = 1'b0; clr_i = 1'b0; mode_i = 3'b100;
    op_a_i = '0; op_b_i = '0; addend_i = '0;
    m_acc = '0; m_cap = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R12 reset state of both registers
    step(3'b100, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R12");
    step(3'b010, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R12");
    // R1 R2 R3 combinational
    step(3'b000, 8'hFF, 8'hFF, 16'h1234, 1'b1, 1'b0, "");
    step(3'b001, 8'hFF, 8'hFF, 16'hFFFF, 1'b1, 1'b0, "");
    step(3'b011, 8'hAB, 8'hCD, 16'hFFFF, 1'b1, 1'b0, "");
    // R6 product captured with a large addend that must not matter
    step(3'b100, 8'h12, 8'h34, 16'hFFFF, 1'b1, 1'b0, "");
    step(3'b100, 8'h00, 8'h00, 16'hFFFF, 1'b0, 1'b0, "R6");
    // R7 R8
    step(3'b101, 8'hFF, 8'h02, 16'h8000, 1'b1, 1'b0, "");
    step(3'b111, 8'h80, 8'h01, 16'hFFFF, 1'b1, 1'b0, "");
    step(3'b111, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R8");
    // R4 then R5 on the same running total (R12 continuation)
    for (int i = 0; i < 4; i++) step(3'b010, 8'h00, 8'h00, 16'h0100, 1'b1, 1'b0, "");
    step(3'b000, 8'h03, 8'h04, 16'h0000, 1'b1, 1'b0, "");
    for (int i = 0; i < 4; i++) step(3'b110, 8'h10, 8'h10, 16'hFFFF, 1'b1, 1'b0, "R12");
    // R10 hold with enable low
    for (int i = 0; i < 3; i++) step(3'b110, 8'hFF, 8'hFF, 16'h0000, 1'b0, 1'b0, "R10");
    for (int i = 0; i < 3; i++) step(3'b101, 8'hFF, 8'hFF, 16'h0001, 1'b0, 1'b0, "R10");
    // R11 clear with enable low
    step(3'b110, 8'hFF, 8'hFF, 16'h0000, 1'b0, 1'b1, "R11");
    step(3'b110, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R11");
    step(3'b101, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "R11");
    // R9 wrap with largest addend, then with largest product
    for (int i = 0; i < 260; i++) step(3'b010, 8'h00, 8'h00, 16'hFFFF, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 270; i++) step(3'b110, 8'hFF, 8'hFF, 16'h0000, 1'b1, 1'b0, "R9");
    // random modes, enables and rare clears
    for (int i = 0; i < 4000; i++)
      step(3'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
           ($urandom % 4) != 0, ($urandom % 64) == 0, "");
    step(3'b000, 8'h00, 8'h00, 16'h0000, 1'b0, 1'b0, "");
    @(negedge clk_i);
    #5;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule